// File: doc/BRIEF.md
# Word DMA Parallel Interface Controller

This block is a 16-bit parallel port with a word-count DMA engine. A host programs it through a small register window: a word address split over two registers, a range count, an address-modifier byte, a control/status word, a one-shot pulse register and a programmed-I/O data register. Once started, the engine moves one word per handshake between a memory request/acknowledge port and an external device word port, in either direction.

End of range, an external attention edge or an error ends a transfer. Both end of range and attention raise flags, and an interrupt request follows while the interrupt enable latch is set. Three function latch outputs go out to the device, and three status inputs come back. When these are looped together, the host can test the path. A master clear returns the block to its reset state and sends a one-cycle init pulse to the device.

Top module: `word_dma_port`

## Requirements
- R1: After reset the control/status word reads 0x0001 (only ready, bit 0, set), and irq, mem_req and dev_init are low.
- R2: The word address is the high register (15 bits, bits 30:16; upper write bits are dropped on readback) joined to the low register (bits 15:0). mem_addr drives the word address shifted left by one. The address increments once per word moved. The address-modifier register drives mem_am.
- R3: A range value of N-1 moves exactly N words. After completion the range register reads 0 and the low address reads start+N. Writes to address, range and data registers are ignored while the engine is not idle.
- R4: On completion the status word has both ready (bit 0) and the DMA end flag (bit 6) set.
- R5: With direction bit 4 clear, each memory word is read and presented on dev_dout with a one-cycle dev_stb, and the data register keeps the last word. With bit 4 set, each dev_din word is written to memory, with one dev_stb per word.
- R6: Pulse register bits act for one cycle and leave the function latches unchanged: bit 0 GO, 1 clear attention, 2 clear DMA flag together with bus and timeout errors, 3 clear parity, 4 master clear, 5 set interrupt enable, 6 clear interrupt enable, 7 cycle, 8 function-2 pulse.
- R7: A control write loads GO (bit 0), function latches 1..3 (bits 3:1), direction (bit 4), interrupt enable (bit 5) and cycle (bit 6). Interrupt enable takes bit 5, so a write without it clears the enable.
- R8: irq goes high one cycle after interrupt enable and at least one of attention or DMA flag are both set. irq_ack clears interrupt enable.
- R9: A rising edge on dev_attn sets the attention flag (bit 7). If the engine is not idle, the edge also ends the transfer and sets the DMA flag, and the word in progress is not counted.
- R10: fcn_o[2:0] carry function latches 1..3, and a function-2 pulse raises fcn_o[1] for one cycle. Status bits 8, 9 and 10 show sts_i[0], sts_i[1] and sts_i[2].
- R11: If a request sees no acknowledge for TMO_CYC consecutive cycles, the transfer ends with the timeout error (bit 13) and the DMA flag set. mem_err during a request ends it with the bus error (bit 12). dev_perr sets the parity error (bit 11).
- R12: Master clear returns every register and flag to its reset value and drives dev_init high for exactly one cycle.
- R13: GO without cycle arms the engine without issuing a request. The transfer starts on a later cycle bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | 3 | Register select: 0 control/status, 1 pulse, 2 address low, 3 address high, 4 range, 5 data, 6 modifier |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data for hst_addr |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (device to memory) |
| mem_addr | output | 32 | Byte address (word address shifted left by one) |
| mem_am | output | 8 | Address modifier |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_err | input | 1 | Memory bus error |
| dev_din | input | 16 | Word from the device |
| dev_dout | output | 16 | Word to the device (data register) |
| dev_stb | output | 1 | One-cycle strobe per word moved |
| dev_attn | input | 1 | Device attention |
| dev_perr | input | 1 | Device parity error |
| dev_init | output | 1 | Init pulse to the device |
| fcn_o | output | 3 | Function latch outputs |
| sts_i | input | 3 | Device status inputs |

## Verification
The bench targets the range arithmetic at length one and at random lengths. A design off by one there would move one word too many or too few, which shows up as a wrong neighbour word in memory or a wrong final address. It arms GO without cycle and watches for a stray request. It raises attention mid-transfer to check that both flags set and that range and address are frozen, since a design that finished the word or accepted writes while busy would read back changed values. It also checks that the timeout fires at the TMO_CYC boundary and not early, that a control write silently drops the interrupt enable, and that the function-2 pulse lasts exactly one cycle.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_REQ} eng_st_t;

  localparam logic [2:0] RA_CSR   = 3'd0;
  localparam logic [2:0] RA_PULSE = 3'd1;
  localparam logic [2:0] RA_ALO   = 3'd2;
  localparam logic [2:0] RA_AHI   = 3'd3;
  localparam logic [2:0] RA_RNG   = 3'd4;
  localparam logic [2:0] RA_DATA  = 3'd5;
  localparam logic [2:0] RA_AMOD  = 3'd6;

  // control write bits
  localparam int CB_GO  = 0;
  localparam int CB_FN1 = 1;
  localparam int CB_FN3 = 3;
  localparam int CB_DIR = 4;
  localparam int CB_IEN = 5;
  localparam int CB_CYC = 6;

  // pulse register bits
  localparam int PB_GO    = 0;
  localparam int PB_RATTN = 1;
  localparam int PB_RDMA  = 2;
  localparam int PB_RPERR = 3;
  localparam int PB_MCLR  = 4;
  localparam int PB_IEN   = 5;
  localparam int PB_MASK  = 6;
  localparam int PB_CYC   = 7;
  localparam int PB_FN2   = 8;
endpackage

// File: rtl/wdp_engine.sv
module wdp_engine import wdp_pkg::*; #(
  parameter int DW      = 16,
  parameter int LO_W    = 16,
  parameter int HI_W    = 15,
  parameter int TMO_CYC = 256,
  localparam int AW     = LO_W + HI_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          go,
  input  logic          cyc,
  input  logic          dir_in,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          ld_rng,
  input  logic          ld_data,
  input  logic [DW-1:0] wdata,
  input  logic          stop,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  input  logic [DW-1:0] dev_din,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] data_q,
  output logic          ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          dev_stb,
  output logic          fin,
  output logic          tmo_set,
  output logic          berr_set
);
  localparam int TW = $clog2(TMO_CYC);

  eng_st_t       st;
  logic          dir_q;
  logic [TW-1:0] tcnt;
  logic          in_req, tmo_hit, abort, word_ok;

  always_comb begin
    in_req   = (st == S_REQ);
    tmo_hit  = in_req && !mem_ack && (tcnt == TW'(TMO_CYC - 1));
    abort    = in_req && (stop || mem_err || tmo_hit);
    word_ok  = in_req && mem_ack && !stop && !mem_err;
    fin      = abort || (word_ok && cnt == '0) || (st == S_ARMED && stop);
    tmo_set  = tmo_hit;
    berr_set = in_req && mem_err;
  end

  assign ready     = (st == S_IDLE);
  assign mem_req   = in_req;
  assign mem_we    = in_req && dir_q;
  assign mem_wdata = dev_din;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      st      <= S_IDLE;
      waddr   <= '0;
      cnt     <= '0;
      data_q  <= '0;
      dir_q   <= 1'b0;
      tcnt    <= '0;
      dev_stb <= 1'b0;
    end else begin
      dev_stb <= word_ok;
      tcnt    <= (in_req && !mem_ack && !tmo_hit) ? tcnt + 1'b1 : '0;
      case (st)
        S_IDLE: begin
          if (ld_lo)   waddr[LO_W-1:0]  <= wdata[LO_W-1:0];
          if (ld_hi)   waddr[AW-1:LO_W] <= wdata[HI_W-1:0];
          if (ld_rng)  cnt    <= wdata;
          if (ld_data) data_q <= wdata;
          if (go) begin
            dir_q <= dir_in;
            st    <= cyc ? S_REQ : S_ARMED;
          end
        end
        S_ARMED: begin
          if (stop)     st <= S_IDLE;
          else if (cyc) st <= S_REQ;
        end
        S_REQ: begin
          if (abort) begin
            st <= S_IDLE;
          end else if (word_ok) begin
            data_q <= dir_q ? dev_din : mem_rdata;
            waddr  <= waddr + 1'b1;
            if (cnt == '0) st <= S_IDLE;
            else           cnt <= cnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  last_word_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_REQ && mem_ack && !mem_err && !stop && cnt == '0) |=> (st == S_IDLE));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_REQ && !mem_ack && !mem_err && !stop && !clr && tcnt != TW'(TMO_CYC - 1))
      |=> (mem_req && $stable(waddr) && $stable(cnt)));

  // R9
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    (st != S_IDLE && stop) |=> (st == S_IDLE));
endmodule

// File: rtl/wdp_flags.sv
module wdp_flags (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic attn_edge,
  input  logic fin,
  input  logic perr_in,
  input  logic berr_set,
  input  logic tmo_set,
  input  logic clr_attn,
  input  logic clr_dma,
  input  logic clr_perr,
  input  logic ien_wr,
  input  logic ien_val,
  input  logic ien_set,
  input  logic ien_mask,
  input  logic irq_ack,
  output logic attn_f,
  output logic dma_f,
  output logic perr_f,
  output logic berr_f,
  output logic terr_f,
  output logic ien_q,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      attn_f <= 1'b0;
      dma_f  <= 1'b0;
      perr_f <= 1'b0;
      berr_f <= 1'b0;
      terr_f <= 1'b0;
      ien_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      attn_f <= attn_edge | (attn_f & ~clr_attn);
      dma_f  <= fin       | (dma_f  & ~clr_dma);
      berr_f <= berr_set  | (berr_f & ~clr_dma);
      terr_f <= tmo_set   | (terr_f & ~clr_dma);
      perr_f <= perr_in   | (perr_f & ~clr_perr);
      if (irq_ack || ien_mask) ien_q <= 1'b0;
      else if (ien_wr)         ien_q <= ien_val;
      else if (ien_set)        ien_q <= 1'b1;
      irq_q <= ien_q & (attn_f | dma_f);
    end
  end

  // R8
  ack_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !ien_q);
endmodule

// File: rtl/word_dma_port.sv
module word_dma_port import wdp_pkg::*; #(
  parameter int DW      = 16,
  parameter int LO_W    = 16,
  parameter int HI_W    = 15,
  parameter int AM_W    = 8,
  parameter int TMO_CYC = 256,
  localparam int AW     = LO_W + HI_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hst_we,
  input  logic [2:0]      hst_addr,
  input  logic [DW-1:0]   hst_wdata,
  output logic [DW-1:0]   hst_rdata,
  output logic            irq,
  input  logic            irq_ack,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW:0]     mem_addr,
  output logic [AM_W-1:0] mem_am,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [DW-1:0]   dev_din,
  output logic [DW-1:0]   dev_dout,
  output logic            dev_stb,
  input  logic            dev_attn,
  input  logic            dev_perr,
  output logic            dev_init,
  output logic [2:0]      fcn_o,
  input  logic [2:0]      sts_i
);
  logic            wr_csr, wr_pls, mclr, go, cyc, dir_go;
  logic [DW-1:0]   pls;
  logic [2:0]      fcn_q;
  logic            dirl_q, fn2_q, attn_q, attn_edge;
  logic [AM_W-1:0] amod_q;
  logic [AW-1:0]   waddr;
  logic [DW-1:0]   cnt, data_q;
  logic            ready, fin, tmo_set, berr_set;
  logic            attn_f, dma_f, perr_f, berr_f, terr_f, ien_q;
  logic [15:0]     csr_v;

  assign wr_csr    = hst_we && (hst_addr == RA_CSR);
  assign wr_pls    = hst_we && (hst_addr == RA_PULSE);
  assign pls       = wr_pls ? hst_wdata : '0;
  assign mclr      = pls[PB_MCLR];
  assign go        = (wr_csr && hst_wdata[CB_GO]) || pls[PB_GO];
  assign cyc       = (wr_csr && hst_wdata[CB_CYC]) || pls[PB_CYC];
  assign dir_go    = wr_csr ? hst_wdata[CB_DIR] : dirl_q;
  assign attn_edge = dev_attn && !attn_q;

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      fcn_q  <= '0;
      dirl_q <= 1'b0;
      amod_q <= '0;
    end else begin
      if (wr_csr) begin
        fcn_q  <= hst_wdata[CB_FN3:CB_FN1];
        dirl_q <= hst_wdata[CB_DIR];
      end
      if (hst_we && hst_addr == RA_AMOD) amod_q <= hst_wdata[AM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fn2_q    <= 1'b0;
      dev_init <= 1'b0;
      attn_q   <= 1'b0;
    end else begin
      fn2_q    <= pls[PB_FN2];
      dev_init <= mclr;
      attn_q   <= dev_attn;
    end
  end

  wdp_engine #(.DW(DW), .LO_W(LO_W), .HI_W(HI_W), .TMO_CYC(TMO_CYC)) eng_i (
    .clk(clk), .rst(rst), .clr(mclr), .go(go), .cyc(cyc), .dir_in(dir_go),
    .ld_lo(hst_we && hst_addr == RA_ALO), .ld_hi(hst_we && hst_addr == RA_AHI),
    .ld_rng(hst_we && hst_addr == RA_RNG), .ld_data(hst_we && hst_addr == RA_DATA),
    .wdata(hst_wdata), .stop(attn_edge), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .dev_din(dev_din), .waddr(waddr), .cnt(cnt),
    .data_q(data_q), .ready(ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .dev_stb(dev_stb), .fin(fin), .tmo_set(tmo_set),
    .berr_set(berr_set)
  );

  wdp_flags flg_i (
    .clk(clk), .rst(rst), .clr(mclr), .attn_edge(attn_edge), .fin(fin),
    .perr_in(dev_perr), .berr_set(berr_set), .tmo_set(tmo_set),
    .clr_attn(pls[PB_RATTN]), .clr_dma(pls[PB_RDMA]), .clr_perr(pls[PB_RPERR]),
    .ien_wr(wr_csr), .ien_val(hst_wdata[CB_IEN]), .ien_set(pls[PB_IEN]),
    .ien_mask(pls[PB_MASK]), .irq_ack(irq_ack), .attn_f(attn_f), .dma_f(dma_f),
    .perr_f(perr_f), .berr_f(berr_f), .terr_f(terr_f), .ien_q(ien_q), .irq_q(irq)
  );

  assign mem_addr = {waddr, 1'b0};
  assign mem_am   = amod_q;
  assign dev_dout = data_q;
  assign fcn_o    = fcn_q | {1'b0, fn2_q, 1'b0};
  assign csr_v    = {2'b00, terr_f, berr_f, perr_f, sts_i[2], sts_i[1], sts_i[0],
                     attn_f, dma_f, ien_q, dirl_q, fcn_q, ready};

  always_comb begin
    case (hst_addr)
      RA_CSR:  hst_rdata = DW'(csr_v);
      RA_ALO:  hst_rdata = DW'(waddr[LO_W-1:0]);
      RA_AHI:  hst_rdata = DW'(waddr[AW-1:LO_W]);
      RA_RNG:  hst_rdata = cnt;
      RA_DATA: hst_rdata = data_q;
      RA_AMOD: hst_rdata = DW'(amod_q);
      default: hst_rdata = '0;
    endcase
  end

  // R12
  init_chk: assert property (@(posedge clk) disable iff (rst)
    dev_init |-> $past(mclr));
endmodule

// File: tb/word_dma_port_tb_top.sv
`timescale 1ns/1ps
module word_dma_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_we = 1'b0;
  logic [2:0]  hst_addr = '0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic        irq, irq_ack = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_am;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [15:0] dev_din = '0, dev_dout;
  logic        dev_stb, dev_attn = 1'b0, dev_perr = 1'b0, dev_init;
  logic [2:0]  fcn_o;

  int ntot = 0, npass = 0, nfail = 0;
  logic [15:0] mem [64];
  logic [15:0] shadow [64];
  logic [15:0] cap [64];
  int ocnt = 0, dev_idx = 0;
  logic [15:0] salt = '0;
  bit hang = 1'b0, err_mode = 1'b0;

  always #10 clk = ~clk;

  word_dma_port dut_i (
    .clk(clk), .rst(rst), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
    .hst_rdata(hst_rdata), .irq(irq), .irq_ack(irq_ack), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_am(mem_am), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err), .dev_din(dev_din),
    .dev_dout(dev_dout), .dev_stb(dev_stb), .dev_attn(dev_attn), .dev_perr(dev_perr),
    .dev_init(dev_init), .fcn_o(fcn_o), .sts_i(fcn_o)
  );

  function automatic logic [15:0] pat(input int i, input logic [15:0] s);
    return 16'h3C00 ^ (16'(i) * 16'h0101) ^ s;
  endfunction

  // device and memory models
  always @(negedge clk) begin
    if (dev_stb) begin
      if (ocnt < 64) cap[ocnt] = dev_dout;
      ocnt = ocnt + 1;
      dev_idx = dev_idx + 1;
      dev_din = pat(dev_idx, salt);
    end
    if (mem_req && !mem_ack && !hang) begin
      mem_ack = 1'b1;
      mem_err = err_mode;
      if (mem_we) mem[mem_addr[6:1]] = mem_wdata;
      else        mem_rdata = mem[mem_addr[6:1]];
    end else begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act === exp) npass++;
    else begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    hst_addr = a; hst_wdata = d; hst_we = 1'b1;
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    hst_addr = a;
    #1;
    v = hst_rdata;
  endtask

  task automatic wait_ready();
    logic [15:0] v;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      rd(3'd0, v);
      if (v[0]) break;
    end
  endtask

  task automatic pulse_attn();
    @(negedge clk); dev_attn = 1'b1;
    @(negedge clk); dev_attn = 1'b0;
  endtask

  task automatic xfer(input int st, input int n, input bit din);
    logic [15:0] v;
    int bad;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'($urandom);
      shadow[i] = mem[i];
    end
    salt = 16'($urandom);
    ocnt = 0; dev_idx = 0; dev_din = pat(0, salt);
    wr(3'd2, 16'(st)); wr(3'd3, 16'h0000); wr(3'd4, 16'(n - 1)); wr(3'd1, 16'h0006);
    wr(3'd0, din ? 16'h0051 : 16'h0041);
    wait_ready();
    rd(3'd0, v);
    chk("R4 ready and dma flag", {30'd0, v[6], v[0]}, 32'd3);
    rd(3'd2, v);
    chk("R3 final address", 32'(v), 32'(st + n));
    rd(3'd4, v);
    chk("R3 final range", 32'(v), 32'd0);
    chk("R5 strobe count", 32'(ocnt), 32'(n));
    bad = 0;
    if (din) begin
      for (int i = 0; i < n; i++) if (mem[st + i] !== pat(i, salt)) bad++;
      chk("R5 device-to-memory words", 32'(bad), 32'd0);
      chk("R3 word after range untouched", 32'(mem[st + n]), 32'(shadow[st + n]));
    end else begin
      for (int i = 0; i < n; i++) if (cap[i] !== shadow[st + i]) bad++;
      chk("R5 memory-to-device words", 32'(bad), 32'd0);
      rd(3'd5, v);
      chk("R5 last word in data reg", 32'(v), 32'(shadow[st + n - 1]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; ntot++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int bad;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v);
    chk("R1 status after reset", 32'(v), 32'h0001);
    chk("R1 outputs after reset", {29'd0, irq, mem_req, dev_init}, 32'd0);

    // R2 high register width, shift and modifier
    wr(3'd3, 16'hFFFF);
    rd(3'd3, v);
    chk("R2 high address width", 32'(v), 32'h7FFF);
    wr(3'd3, 16'h0000);
    wr(3'd6, 16'h003D);
    wr(3'd2, 16'd5); wr(3'd4, 16'd0);
    wr(3'd0, 16'h0041);
    chk("R2 byte address on port", mem_addr, 32'd10);
    chk("R2 modifier on port", 32'(mem_am), 32'h3D);
    wait_ready();
    rd(3'd2, v);
    chk("R3 single word range", 32'(v), 32'd6);

    // R3 R4 R5 random transfers
    for (int t = 0; t < 10; t++)
      xfer($urandom_range(0, 40), $urandom_range(1, 16), 1'($urandom_range(0, 1)));
    xfer(0, 1, 1'b1);

    // R13 arm without cycle
    wr(3'd2, 16'd7); wr(3'd4, 16'd1);
    wr(3'd0, 16'h0001);
    bad = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (mem_req) bad++;
    end
    rd(3'd0, v);
    chk("R13 armed issues no request", {bad[30:0], v[0]}, 32'd0);
    wr(3'd1, 16'h0080);
    wait_ready();
    rd(3'd2, v);
    chk("R13 cycle pulse starts transfer", 32'(v), 32'd9);

    // R10 loopback, R6 pulse leaves latches
    wr(3'd0, 16'h000A);
    chk("R10 function outputs", 32'(fcn_o), 32'h5);
    rd(3'd0, v);
    chk("R10 status A B C", 32'(v[10:8]), 32'h5);
    wr(3'd1, 16'h0100);
    rd(3'd0, v);
    chk("R10 function-2 pulse shows on B", {v[9], v[3:1]}, 32'hD);
    @(negedge clk);
    rd(3'd0, v);
    chk("R10 function-2 pulse lasts one cycle", 32'(v[9]), 32'd0);
    wr(3'd1, 16'h0004);
    rd(3'd0, v);
    chk("R6 clear dma keeps function latches", {v[6], v[3:1]}, 32'h5);

    // R8 enable without flags, R9 idle attention
    wr(3'd1, 16'h0020);
    repeat (2) @(negedge clk);
    chk("R8 no irq without flag", 32'(irq), 32'd0);
    pulse_attn();
    rd(3'd0, v);
    chk("R9 idle attention sets only attention", {v[7], v[6]}, 32'h2);
    repeat (2) @(negedge clk);
    chk("R8 irq with enable and flag", 32'(irq), 32'd1);
    wr(3'd0, 16'h000A);
    repeat (2) @(negedge clk);
    rd(3'd0, v);
    chk("R7 control write drops enable", {irq, v[5]}, 32'd0);
    wr(3'd0, 16'h002A);
    repeat (2) @(negedge clk);
    chk("R7 control write sets enable", 32'(irq), 32'd1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd0, v);
    chk("R8 acknowledge clears enable", {irq, v[5]}, 32'd0);
    wr(3'd1, 16'h0002);

    // R9 attention during DMA, R3 writes ignored while busy
    hang = 1'b1;
    wr(3'd2, 16'd3); wr(3'd4, 16'd4);
    wr(3'd0, 16'h0041);
    repeat (5) @(negedge clk);
    wr(3'd4, 16'h0077); wr(3'd2, 16'h0020);
    pulse_attn();
    rd(3'd0, v);
    chk("R9 attention ends transfer with both flags", {v[7], v[6], v[0]}, 32'h7);
    rd(3'd4, v);
    chk("R3 range write ignored while busy", 32'(v), 32'd4);
    rd(3'd2, v);
    chk("R9 no word counted on stop", 32'(v), 32'd3);
    wr(3'd1, 16'h0006);

    // R11 timeout window
    wr(3'd0, 16'h0041);
    repeat (250) @(negedge clk);
    rd(3'd0, v);
    chk("R11 no early timeout", 32'(v[0]), 32'd0);
    repeat (50) @(negedge clk);
    rd(3'd0, v);
    chk("R11 timeout error and end", {v[13], v[6], v[0]}, 32'h7);
    hang = 1'b0;
    wr(3'd1, 16'h0004);
    rd(3'd0, v);
    chk("R11 clear dma clears timeout", {v[13], v[6]}, 32'd0);

    // R11 bus error
    err_mode = 1'b1;
    wr(3'd2, 16'd0); wr(3'd4, 16'd2);
    wr(3'd0, 16'h0041);
    wait_ready();
    err_mode = 1'b0;
    rd(3'd0, v);
    chk("R11 bus error ends transfer", {v[12], v[6]}, 32'h3);
    rd(3'd2, v);
    chk("R11 failed word not counted", 32'(v), 32'd0);

    // R11 parity
    @(negedge clk); dev_perr = 1'b1;
    @(negedge clk); dev_perr = 1'b0;
    rd(3'd0, v);
    chk("R11 parity error set", 32'(v[11]), 32'd1);
    wr(3'd1, 16'h0008);
    rd(3'd0, v);
    chk("R6 clear parity pulse", 32'(v[11]), 32'd0);

    // R12 master clear
    wr(3'd0, 16'h000A);
    wr(3'd1, 16'h0010);
    chk("R12 init pulse", 32'(dev_init), 32'd1);
    rd(3'd0, v);
    chk("R12 status back to reset", 32'(v), 32'h0001);
    @(negedge clk);
    chk("R12 init pulse one cycle", 32'(dev_init), 32'd0);
    rd(3'd6, v);
    chk("R12 modifier cleared", 32'(v), 32'd0);

    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end
endmodule